// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is a single 32-pin general-purpose I/O bank that a host processor programs through a plain request port made of valid, write, address and data signals. Each pin is governed by one bit in each of several 32-bit control words. These words set the output value, the pin direction, the interrupt enable and three interrupt-sense bits. Further words hold a pending-interrupt status and a reset-hold flag. Pad inputs pass through a two-flop synchronizer before any edge or level detection.

Each pin has a sense mode, built from its three sense bits. A pin's status bit latches when the selected event occurs, whether or not the pin's enable bit is set. The single interrupt output is raised whenever a pending pin is also enabled. Software clears pending bits by writing ones to the status word. A pin in a level mode keeps re-arming its status for as long as the level holds.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every control word and the status word read as zero, `pad_oe` and `pad_out` are zero and `irq` is low.
- R2: Word addresses are 0 output value, 1 direction, 2 interrupt enable, 3 sense bit A, 4 sense bit B, 5 sense bit C, 6 status, 7 reset-hold. A write stores the whole word (status excepted, see R7). A read returns the word on `bus_rdata` with `bus_rvalid` high one clock after the request. A status read returns all 32 pending bits together.
- R3: `pad_oe` equals the direction word (1 = output) and `pad_out` equals the output-value word. A read of address 0 returns the stored value for output pins and the synchronized pad level for input pins.
- R4: With sense bit B clear, a pin senses a falling edge when A and C are both 0, a rising edge when only A is 1, and both edges when C is 1.
- R5: With sense bit B set, a pin senses a low level when A is 0 and a high level when A is 1. C is ignored.
- R6: A status bit latches on its pin's event even while the pin's enable is 0. `irq` is the OR over pins of status AND enable.
- R7: Writing address 6 clears each status bit whose write-data bit is 1. Zero bits leave status unchanged.
- R8: In a level mode the status bit is set again on every clock while the level holds, so a clear issued during the level does not stick. Once the level is gone, a clear does stick.
- R9: A pad change applied just after a clock edge shows in status, and in `irq` if enabled, right after the third following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one clock after a read request |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the edge that samples it, so `pad_oe`, `pad_out` and `irq` are checked at the falling edge right after the write. Read data comes one edge after the request. The bench queues the expected word when it issues each read, and compares it when `bus_rvalid` appears. A pad change reaches status three rising edges later. The bench therefore waits at least four cycles after each pad change before reading status, and for the latency requirement it samples `irq` at each of the three falling edges after the pad change.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    A_OUTVAL = 3'd0,
    A_DIR    = 3'd1,
    A_IEN    = 3'd2,
    A_SNSA   = 3'd3,
    A_SNSB   = 3'd4,
    A_SNSC   = 3'd5,
    A_STAT   = 3'd6,
    A_HOLD   = 3'd7
  } word_addr_e;

  typedef enum logic [2:0] {
    SNS_FALL = 3'd0,
    SNS_RISE = 3'd1,
    SNS_BOTH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_HIGH = 3'd4
  } sense_e;

  function automatic sense_e decode_sense(input logic sa, input logic sb, input logic sc);
    sense_e m;
    if (sb)      m = sa ? SNS_HIGH : SNS_LOW;
    else if (sc) m = SNS_BOTH;
    else if (sa) m = SNS_RISE;
    else         m = SNS_FALL;
    return m;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_now,
  input  logic [NPINS-1:0] sns_a,
  input  logic [NPINS-1:0] sns_b,
  input  logic [NPINS-1:0] sns_c,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] set_vec;
  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] status_d;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    sense_e mode;
    always_comb begin
      mode = decode_sense(sns_a[p], sns_b[p], sns_c[p]);
      unique case (mode)
        SNS_FALL: set_vec[p] = prev_q[p] & ~pin_now[p];
        SNS_RISE: set_vec[p] = ~prev_q[p] & pin_now[p];
        SNS_BOTH: set_vec[p] = prev_q[p] ^ pin_now[p];
        SNS_LOW:  set_vec[p] = ~pin_now[p];
        SNS_HIGH: set_vec[p] = pin_now[p];
        default:  set_vec[p] = 1'b0;
      endcase
    end
  end

  always_comb status_d = (status_q & ~clr_mask) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= pin_now;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_vec)) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q & ~clr_mask)) == '0)); // R7
  AST_LEVEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0) |=> ((status_q & ~$past(status_q)) == '0)); // R4
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [NPINS-1:0] req_wdata,
  input  logic [NPINS-1:0] pad_sync,
  input  logic [NPINS-1:0] status,
  output logic [NPINS-1:0] out_val,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] sns_a,
  output logic [NPINS-1:0] sns_b,
  output logic [NPINS-1:0] sns_c,
  output logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] rd_data,
  output logic             rd_valid
);
  localparam int unsigned NWORDS = 1 << AW;

  logic [NWORDS-1:0] wr_sel;
  logic              rd_en;
  logic [NPINS-1:0]  outval_q, dir_q, ien_q, sa_q, sb_q, sc_q, hold_q;
  logic [NPINS-1:0]  rd_data_q, rd_data_d;
  logic              rd_valid_q;
  logic [NPINS-1:0]  pin_view;

  for (genvar w = 0; w < NWORDS; w++) begin : g_sel
    assign wr_sel[w] = req_valid & req_write & (req_addr == AW'(w));
  end

  assign rd_en    = req_valid & ~req_write;
  assign clr_mask = wr_sel[A_STAT] ? req_wdata : '0;
  assign pin_view = (dir_q & outval_q) | (~dir_q & pad_sync);

  always_comb begin
    unique case (word_addr_e'(req_addr))
      A_OUTVAL: rd_data_d = pin_view;
      A_DIR:    rd_data_d = dir_q;
      A_IEN:    rd_data_d = ien_q;
      A_SNSA:   rd_data_d = sa_q;
      A_SNSB:   rd_data_d = sb_q;
      A_SNSC:   rd_data_d = sc_q;
      A_STAT:   rd_data_d = status;
      A_HOLD:   rd_data_d = hold_q;
      default:  rd_data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outval_q   <= '0;
      dir_q      <= '0;
      ien_q      <= '0;
      sa_q       <= '0;
      sb_q       <= '0;
      sc_q       <= '0;
      hold_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_sel[A_OUTVAL]) outval_q <= req_wdata;
      if (wr_sel[A_DIR])    dir_q    <= req_wdata;
      if (wr_sel[A_IEN])    ien_q    <= req_wdata;
      if (wr_sel[A_SNSA])   sa_q     <= req_wdata;
      if (wr_sel[A_SNSB])   sb_q     <= req_wdata;
      if (wr_sel[A_SNSC])   sc_q     <= req_wdata;
      if (wr_sel[A_HOLD])   hold_q   <= req_wdata;
      if (rd_en)            rd_data_q <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign out_val  = outval_q;
  assign dir      = dir_q;
  assign ien      = ien_q;
  assign sns_a    = sa_q;
  assign sns_b    = sb_q;
  assign sns_c    = sc_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  AST_READ_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid_q); // R2
  AST_ACK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(req_valid && !req_write)); // R2
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic             srst_n;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] out_val, dir, ien, sns_a, sns_b, sns_c, clr_mask;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpio_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (srst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (bus_valid),
    .req_write (bus_write),
    .req_addr  (bus_addr),
    .req_wdata (bus_wdata),
    .pad_sync  (pad_sync),
    .status    (status),
    .out_val   (out_val),
    .dir       (dir),
    .ien       (ien),
    .sns_a     (sns_a),
    .sns_b     (sns_b),
    .sns_c     (sns_c),
    .clr_mask  (clr_mask),
    .rd_data   (bus_rdata),
    .rd_valid  (bus_rvalid)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst_n    (srst_n),
    .pin_now  (pad_sync),
    .sns_a    (sns_a),
    .sns_b    (sns_b),
    .sns_c    (sns_c),
    .clr_mask (clr_mask),
    .status   (status)
  );

  assign pad_out = out_val;
  assign pad_oe  = dir;
  assign irq     = |(status & ien);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!srst_n)
    (ien == '0) |-> !irq); // R6
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!srst_n)
    (status == '0) |-> !irq); // R6
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in, pad_out, pad_oe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [2:0]  addr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  // Monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data actual=%h expected=no read", bus_rdata);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_t it;
    it.exp = e; it.addr = a; it.tag = t;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk(pad_oe, 32'd0, "R1 pad_oe");
    chk(pad_out, 32'd0, "R1 pad_out");
    for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R1 reset read");

    // R2/R3 register storage and pin direction
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd0, 32'h1234_5678);
    wr(3'd7, 32'hA5A5_A5A5);
    chk(pad_oe, 32'h0000_FFFF, "R3 pad_oe");
    chk(pad_out, 32'h1234_5678, "R3 pad_out");
    pad_in = 32'hCAFE_0000;
    step(4);
    rd(3'd0, 32'hCAFE_5678, "R3 mixed readback");
    rd(3'd1, 32'h0000_FFFF, "R2 dir readback");
    rd(3'd7, 32'hA5A5_A5A5, "R2 hold readback");
    wr(3'd1, 32'h0);
    chk(pad_oe, 32'h0, "R3 all inputs");
    rd(3'd0, 32'hCAFE_0000, "R3 input readback");

    // R4 falling edge default mode on the upper pins
    pad_in = 32'h0000_0008;
    step(4);
    rd(3'd6, 32'hCAFE_0000, "R4 falling default");
    wr(3'd3, 32'h0000_0016);
    wr(3'd4, 32'h0000_0018);
    wr(3'd5, 32'h0000_0004);
    step(2);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0, "R7 clear all");

    pad_in = 32'h0000_000F;
    step(4);
    rd(3'd6, 32'h0000_0006, "R4 rising and both");
    chk({31'd0, irq}, 32'd0, "R6 latched but masked");
    pad_in = 32'h0000_0008;
    step(4);
    rd(3'd6, 32'h0000_0007, "R4 falling and both");

    wr(3'd6, 32'h0000_0005);
    rd(3'd6, 32'h0000_0002, "R7 partial clear");
    wr(3'd6, 32'h0);
    rd(3'd6, 32'h0000_0002, "R7 zero write no effect");
    wr(3'd2, 32'h0000_0002);
    chk({31'd0, irq}, 32'd1, "R6 enabled pending");
    wr(3'd2, 32'h0000_0001);
    chk({31'd0, irq}, 32'd0, "R6 other pin enabled");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0, "R7 clear all again");

    // R5/R8 level modes
    pad_in = 32'h0000_0000;
    step(4);
    rd(3'd6, 32'h0000_0008, "R5 low level");
    wr(3'd6, 32'h0000_0008);
    rd(3'd6, 32'h0000_0008, "R8 low level rearms");
    pad_in = 32'h0000_0018;
    step(4);
    rd(3'd6, 32'h0000_0018, "R5 high level");
    wr(3'd6, 32'h0000_0018);
    rd(3'd6, 32'h0000_0010, "R8 high holds low released");
    pad_in = 32'h0000_0008;
    step(4);
    wr(3'd6, 32'h0000_0010);
    rd(3'd6, 32'h0, "R8 clear after level gone");

    // R9 latency from pad to irq
    wr(3'd2, 32'h0000_0002);
    pad_in = 32'h0000_000A;
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R9 after one edge");
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R9 after two edges");
    @(negedge clk);
    chk({31'd0, irq}, 32'd1, "R9 after three edges");
    wr(3'd6, 32'h0000_0002);
    chk({31'd0, irq}, 32'd0, "R7 clear drops irq");

    step(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing read data actual=%0d expected=0 pending", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule